// File: doc/BRIEF.md
# Light Level Window Alarm

This block watches a stream of 16-bit light conversion results. Each result is checked against a window whose two edges come from 8-bit settings. Each setting is the upper byte of its edge, and the lower byte of the edge is zero. Results that fall outside the window are counted as a run. A result counts only when its valid strobe is high. An in-window result breaks the run.

When the run reaches the length chosen by a 2-bit persistence code, an alarm flag is latched. The same cycle drives an open-drain pull-down enable for an active-low interrupt line. The alarm stays set until the host pulses a clear input. Register access and the conversion itself belong to neighbouring logic.

Top module: `lux_window_alarm`

## Requirements
- R1: The upper edge is `{thr_hi_byte, 8'h00}`. A valid result strictly above it is out of window, and a result equal to it is in window. With the power-up byte 0xFF, the result 0xFF00 is in window and 0xFF01 is out.
- R2: The lower edge is `{thr_lo_byte, 8'h00}`. A valid result strictly below it is out of window, and a result equal to it is in window. With the power-up byte 0x00, no result is below the edge.
- R3: Persistence codes 0, 1, 2 and 3 need runs of 1, 4, 8 and 16 consecutive out-of-window results. The flag is set on the clock edge that takes the last result of the run, so it is visible in the next cycle.
- R4: An in-window valid result sets the run length to zero.
- R5: Once set, `irq_flag` stays 1 through idle cycles and through in-window or out-of-window results, until a clear arrives.
- R6: A clear pulse with no result in the same cycle drops the flag in the next cycle and sets the run length to zero.
- R7: When a clear and a result that completes a run arrive in the same cycle, the flag is 1 in the next cycle.
- R8: `irq_pull_low` is 1 exactly when `irq_flag` is 1, so the interrupt line is low while the alarm is set.
- R9: Synchronous active-high reset leaves the flag, the pull-down enable and the run length at zero.
- R10: Cycles with `smp_vld` low do not change the run length. Consecutive means consecutive valid results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Result strobe |
| smp_data | input | 16 | Conversion result |
| thr_hi_byte | input | 8 | Upper edge, high byte |
| thr_lo_byte | input | 8 | Lower edge, high byte |
| persist_code | input | 2 | Run length select |
| irq_clr | input | 1 | Host clear pulse |
| irq_flag | output | 1 | Alarm latched |
| irq_pull_low | output | 1 | Open-drain pull-down enable |

## Verification
The stimulus places results exactly on each window edge and one count past it. This separates strict comparison from inclusive comparison, and it catches a wrong low byte in either edge. Runs are made one short of each persistence length and then exactly that length. They are also broken by an in-window result, interrupted by idle cycles, or split by a clear. Each of these tells a miscoded length apart from a counter that does not reset. Clear is also issued together with a completing result, which shows the priority between the two.

// File: rtl/lux_alarm_pkg.sv
package lux_alarm_pkg;
    localparam int DATA_W  = 16;
    localparam int THR_W   = 8;
    localparam int PCODE_W = 2;
    localparam int PAD_W   = DATA_W - THR_W;
    localparam int MAX_RUN = 16;
    localparam int RUN_W   = $clog2(MAX_RUN + 1);

    typedef logic [RUN_W-1:0] run_t;

    typedef struct packed {
        logic above;
        logic below;
    } win_cmp_t;

    // run length needed per code: 1, 4, 8, 16
    function automatic run_t persist_need(input logic [PCODE_W-1:0] code);
        if (code == '0)
            return run_t'(1);
        return run_t'(1) << ({1'b0, code} + 3'd1);
    endfunction
endpackage

// File: rtl/lxa_window_cmp.sv
module lxa_window_cmp
    import lux_alarm_pkg::*;
(
    input  logic [DATA_W-1:0] smp_data,
    input  logic [THR_W-1:0]  edge_hi,
    input  logic [THR_W-1:0]  edge_lo,
    output win_cmp_t          cmp
);
    logic [THR_W-1:0] top_part;
    logic             low_nonzero;

    assign top_part    = smp_data[DATA_W-1:PAD_W];
    assign low_nonzero = |smp_data[PAD_W-1:0];

    // edges have a zero low part, so only the high byte needs a magnitude compare
    always_comb begin
        cmp.above = (top_part > edge_hi) || ((top_part == edge_hi) && low_nonzero);
        cmp.below = (top_part < edge_lo);
    end
endmodule

// File: rtl/lxa_run_counter.sv
module lxa_run_counter
    import lux_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic smp_vld,
    input  logic out_win,
    input  logic clr,
    input  run_t need,
    output run_t run_cnt,
    output logic trip
);
    run_t cnt_q;
    run_t cnt_inc;

    assign cnt_inc = (cnt_q == run_t'(MAX_RUN)) ? cnt_q : cnt_q + run_t'(1);
    assign trip    = smp_vld && out_win && (cnt_inc >= need);
    assign run_cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (smp_vld)
            cnt_q <= out_win ? cnt_inc : '0;
        else if (clr)
            cnt_q <= '0;
    end
endmodule

// File: rtl/lxa_alarm_latch.sv
module lxa_alarm_latch (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (trip)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/lux_window_alarm.sv
module lux_window_alarm
    import lux_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [THR_W-1:0]  thr_hi_byte,
    input  logic [THR_W-1:0]  thr_lo_byte,
    input  logic [PCODE_W-1:0] persist_code,
    input  logic              irq_clr,
    output logic              irq_flag,
    output logic              irq_pull_low
);
    win_cmp_t cmp;
    run_t     need;
    run_t     run_cnt;
    logic     trip;
    logic     out_win;

    lxa_window_cmp u_cmp (
        .smp_data (smp_data),
        .edge_hi  (thr_hi_byte),
        .edge_lo  (thr_lo_byte),
        .cmp      (cmp)
    );

    assign out_win = cmp.above | cmp.below;
    assign need    = persist_need(persist_code);

    lxa_run_counter u_run (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld),
        .out_win (out_win),
        .clr     (irq_clr),
        .need    (need),
        .run_cnt (run_cnt),
        .trip    (trip)
    );

    lxa_alarm_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .trip (trip),
        .clr  (irq_clr),
        .flag (irq_flag)
    );

    assign irq_pull_low = irq_flag;
endmodule

// File: rtl/lux_window_alarm_chk.sv
module lux_window_alarm_chk
    import lux_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              smp_vld,
    input logic [DATA_W-1:0] smp_data,
    input logic [THR_W-1:0]  thr_hi_byte,
    input logic [THR_W-1:0]  thr_lo_byte,
    input logic [PCODE_W-1:0] persist_code,
    input logic              irq_clr,
    input logic              irq_flag,
    input logic              irq_pull_low,
    input run_t              run_cnt
);
    logic oow;
    assign oow = (smp_data > {thr_hi_byte, {PAD_W{1'b0}}}) ||
                 (smp_data < {thr_lo_byte, {PAD_W{1'b0}}});

    p_rise_needs_oow_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $past(smp_vld && oow));

    p_code0_single_r3: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && oow && persist_code == '0) |=> irq_flag);

    p_run_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= run_t'(MAX_RUN));

    p_inwin_resets_r4: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !oow) |=> (run_cnt == '0));

    p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    p_clear_drops_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !smp_vld) |=> (!irq_flag && run_cnt == '0));

    p_trigger_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && smp_vld && oow && persist_code == '0) |=> irq_flag);

    p_idle_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (!smp_vld && !irq_clr) |=> $stable(run_cnt));

    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (!irq_flag && !irq_pull_low && run_cnt == '0));
endmodule

bind lux_window_alarm lux_window_alarm_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .smp_vld      (smp_vld),
    .smp_data     (smp_data),
    .thr_hi_byte  (thr_hi_byte),
    .thr_lo_byte  (thr_lo_byte),
    .persist_code (persist_code),
    .irq_clr      (irq_clr),
    .irq_flag     (irq_flag),
    .irq_pull_low (irq_pull_low),
    .run_cnt      (run_cnt)
);

// File: tb/sim_lux_window_alarm.sv
`timescale 1ns/1ps
module sim_lux_window_alarm;
    logic        clk = 1'b0;
    logic        rst;
    logic        smp_vld;
    logic [15:0] smp_data;
    logic [7:0]  thr_hi_byte;
    logic [7:0]  thr_lo_byte;
    logic [1:0]  persist_code;
    logic        irq_clr;
    logic        irq_flag;
    logic        irq_pull_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lux_window_alarm u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .thr_hi_byte(thr_hi_byte), .thr_lo_byte(thr_lo_byte),
        .persist_code(persist_code), .irq_clr(irq_clr),
        .irq_flag(irq_flag), .irq_pull_low(irq_pull_low)
    );

    typedef struct packed {
        logic        clr;
        logic        vld;
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic [1:0]  code;
        logic [15:0] data;
        logic        exp;
    } vec_t;

    localparam int NV = 48;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,8'hFF,8'h00,2'd0,16'hFF00,1'b0}, // 0  R1 equal upper edge
        '{1'b0,1'b1,8'hFF,8'h00,2'd0,16'h0000,1'b0}, // 1  R2 zero lower edge
        '{1'b0,1'b1,8'hFF,8'h00,2'd0,16'hFF01,1'b1}, // 2  R1 R3 one above
        '{1'b1,1'b0,8'hFF,8'h00,2'd0,16'h0000,1'b0}, // 3  R6 clear
        '{1'b0,1'b1,8'h40,8'h10,2'd0,16'h4000,1'b0}, // 4  R1
        '{1'b0,1'b1,8'h40,8'h10,2'd0,16'h1000,1'b0}, // 5  R2 equal lower edge
        '{1'b0,1'b1,8'h40,8'h10,2'd0,16'h0FFF,1'b1}, // 6  R2 one below
        '{1'b0,1'b0,8'h40,8'h10,2'd0,16'h0000,1'b1}, // 7  R5 idle
        '{1'b0,1'b1,8'h40,8'h10,2'd0,16'h2000,1'b1}, // 8  R5 in-window
        '{1'b1,1'b0,8'h40,8'h10,2'd0,16'h0000,1'b0}, // 9  R6
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 10 R3 code 1
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 11
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 12
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b1}, // 13 R3 fourth
        '{1'b1,1'b0,8'h40,8'h10,2'd1,16'h0000,1'b0}, // 14
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 15 R4 run
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 16
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h0800,1'b0}, // 17 below, run 3
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h2000,1'b0}, // 18 R4 break
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 19
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 20
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 21
        '{1'b0,1'b0,8'h40,8'h10,2'd1,16'h2000,1'b0}, // 22 R10 gap
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b1}, // 23 R4 R10
        '{1'b1,1'b0,8'h40,8'h10,2'd1,16'h0000,1'b0}, // 24
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 25 R6 run
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 26
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 27
        '{1'b1,1'b0,8'h40,8'h10,2'd1,16'h0000,1'b0}, // 28 R6 clears run
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 29
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 30
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 31
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b1}, // 32
        '{1'b1,1'b0,8'h40,8'h10,2'd2,16'h0000,1'b0}, // 33
        '{1'b0,1'b1,8'h40,8'h10,2'd2,16'hF000,1'b0}, // 34 R3 code 2
        '{1'b0,1'b1,8'h40,8'h10,2'd2,16'hF000,1'b0}, // 35
        '{1'b0,1'b1,8'h40,8'h10,2'd2,16'hF000,1'b0}, // 36
        '{1'b0,1'b1,8'h40,8'h10,2'd2,16'hF000,1'b0}, // 37
        '{1'b0,1'b1,8'h40,8'h10,2'd2,16'hF000,1'b0}, // 38
        '{1'b0,1'b1,8'h40,8'h10,2'd2,16'hF000,1'b0}, // 39
        '{1'b0,1'b1,8'h40,8'h10,2'd2,16'hF000,1'b0}, // 40
        '{1'b0,1'b1,8'h40,8'h10,2'd2,16'hF000,1'b1}, // 41 R3 eighth
        '{1'b1,1'b0,8'h40,8'h10,2'd1,16'h0000,1'b0}, // 42
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 43 R7 run
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 44
        '{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, // 45
        '{1'b1,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b1}, // 46 R7 clear + trip
        '{1'b1,1'b0,8'h40,8'h10,2'd1,16'h0000,1'b0}  // 47
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic step(input vec_t v, input string req);
        smp_vld = v.vld; smp_data = v.data; irq_clr = v.clr;
        thr_hi_byte = v.hi; thr_lo_byte = v.lo; persist_code = v.code;
        @(negedge clk);
        check(req, irq_flag, v.exp);
        check("R8", irq_pull_low, v.exp);
        smp_vld = 1'b0; irq_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; smp_vld = 1'b0; smp_data = '0; irq_clr = 1'b0;
        thr_hi_byte = 8'hFF; thr_lo_byte = 8'h00; persist_code = 2'd0;
        repeat (3) @(negedge clk);
        check("R9", irq_flag, 1'b0);
        check("R9", irq_pull_low, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            step(TBL[i], $sformatf("vec%0d", i));

        // R3: code 3 needs sixteen results
        for (int i = 0; i < 16; i++)
            step('{1'b0,1'b1,8'h40,8'h10,2'd3,16'hFFFF,(i == 15)}, "R3 code3");
        step('{1'b1,1'b0,8'h40,8'h10,2'd3,16'h0000,1'b0}, "R6");

        // R9: reset drops a set flag and clears a partial run
        step('{1'b0,1'b1,8'h40,8'h10,2'd0,16'hFFFF,1'b1}, "R3");
        rst = 1'b1;
        @(negedge clk);
        check("R9", irq_flag, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++)
            step('{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, "R3");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        step('{1'b0,1'b1,8'h40,8'h10,2'd1,16'h5000,1'b0}, "R9 run cleared");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule